// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the two low-order address bits for a four-beat memory burst. When an access starts, a load strobe captures the low bits of the external address, and that value is presented as the first beat. Each later cycle with the active-low advance input asserted moves to the next beat. The beat order is either a wrapping linear count or an interleaved order. In the interleaved order each beat is the start value XORed with the beat number. A static order-select input chooses between the two.

The upper address bits bypass the block. A small controller tracks the burst with four named states. ST_IDLE means no burst has been loaded since reset. ST_LOADED means a start was captured in the previous cycle. ST_STEP means the last cycle advanced. ST_HOLD means the last cycle waited.

The transitions are as follows. From any state, a load goes to ST_LOADED. From ST_LOADED, ST_STEP or ST_HOLD, an advance without a load goes to ST_STEP. From those same states, a cycle with neither a load nor an advance goes to ST_HOLD. ST_IDLE stays in ST_IDLE until a load arrives. A beat counter starts from zero, and a mapper combines it with the captured start value.

Top module: `burst_seq_gen`

## Requirements
- R1: While reset is asserted and after its release, before any load, `burst_lo` is 00.
- R2: A clock edge with `start` high captures `ext_lo`, and from that edge `burst_lo` equals the captured value (the first beat).
- R3: With `order_sel` = 0 (linear), after k advances since the load `burst_lo` = (start value + k) mod 4.
- R4: With `order_sel` = 1 (interleaved), after k advances since the load `burst_lo` = start value XOR (k mod 4).
- R5: A clock edge with `start` low and `adv_n` high leaves `burst_lo` unchanged (wait cycle).
- R6: When `start` is high and `adv_n` is low on the same edge, the load wins: `burst_lo` becomes the new `ext_lo` and the beat count restarts at 0.
- R7: Advancing past the fourth beat wraps to the first beat of the same group, with no limit on the number of wraps.
- R8: An advance before any load since reset has no effect, and `burst_lo` stays 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load strobe: capture `ext_lo` and begin a burst |
| adv_n | input | 1 | Active-low advance; high means wait |
| order_sel | input | 1 | 0 selects linear order, 1 selects interleaved order (static) |
| ext_lo | input | BEAT_BITS | Low bits of the external start address |
| burst_lo | output | BEAT_BITS | Current burst address low bits |

## Verification
The bench uses the default BEAT_BITS = 2, which gives a four-beat group. With this setting every start value in both orders can be swept. Each sweep runs through eight advances, so every beat and the wrap back into the group are visited twice. Because the configuration is this small, the sweep also lets waits and same-cycle load/advance collisions be placed at chosen beats, and expected addresses are computed with plain modular arithmetic.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOADED = 2'd1,
        ST_STEP   = 2'd2,
        ST_HOLD   = 2'd3
    } seq_state_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_t;
endpackage

// File: rtl/bseq_ctrl.sv
module bseq_ctrl
    import bseq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       adv_n,
    output logic       cnt_clear,
    output logic       cnt_inc,
    output seq_state_t state
);
    seq_state_t state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) state_nx = ST_LOADED;
            end
            ST_LOADED, ST_STEP, ST_HOLD: begin
                if (start)       state_nx = ST_LOADED;
                else if (!adv_n) state_nx = ST_STEP;
                else             state_nx = ST_HOLD;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                cnt_clear = start;
            end
            ST_LOADED, ST_STEP, ST_HOLD: begin
                cnt_clear = start;
                cnt_inc   = !start && !adv_n;
            end
            default: ;
        endcase
    end

    AST_IDLE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !start) |=> state == ST_IDLE); // R8
    AST_LOAD_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> state == ST_LOADED); // R6
endmodule

// File: rtl/bseq_count.sv
module bseq_count #(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 inc,
    input  logic [BEAT_BITS-1:0] load_val,
    output logic [BEAT_BITS-1:0] base,
    output logic [BEAT_BITS-1:0] count
);
    localparam logic [BEAT_BITS-1:0] ONE = BEAT_BITS'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base  <= '0;
            count <= '0;
        end else if (clear) begin
            base  <= load_val;
            count <= '0;
        end else if (inc) begin
            count <= count + ONE;
        end
    end

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> count == '0); // R2
    AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clear) |=> count == $past(count) + ONE); // R7
    AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> $stable(base)); // R5
endmodule

// File: rtl/bseq_map.sv
module bseq_map
    import bseq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic                 order_sel,
    input  logic [BEAT_BITS-1:0] base,
    input  logic [BEAT_BITS-1:0] count,
    output logic [BEAT_BITS-1:0] addr
);
    order_t ord;
    assign ord = order_t'(order_sel);

    always_comb begin
        unique case (ord)
            ORD_LINEAR:     addr = base + count;
            ORD_INTERLEAVE: addr = base ^ count;
            default:        addr = base;
        endcase
    end
endmodule

// File: rtl/burst_seq_gen.sv
module burst_seq_gen
    import bseq_pkg::*;
#(
    parameter int BEAT_BITS = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 adv_n,
    input  logic                 order_sel,
    input  logic [BEAT_BITS-1:0] ext_lo,
    output logic [BEAT_BITS-1:0] burst_lo
);
    logic                 cnt_clear;
    logic                 cnt_inc;
    seq_state_t           state;
    logic [BEAT_BITS-1:0] base;
    logic [BEAT_BITS-1:0] count;

    bseq_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .adv_n    (adv_n),
        .cnt_clear(cnt_clear),
        .cnt_inc  (cnt_inc),
        .state    (state)
    );

    bseq_count #(.BEAT_BITS(BEAT_BITS)) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cnt_clear),
        .inc     (cnt_inc),
        .load_val(ext_lo),
        .base    (base),
        .count   (count)
    );

    bseq_map #(.BEAT_BITS(BEAT_BITS)) u_map (
        .order_sel(order_sel),
        .base     (base),
        .count    (count),
        .addr     (burst_lo)
    );

    AST_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> burst_lo == $past(ext_lo)); // R2
    AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && adv_n) |=> $stable(burst_lo)); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> burst_lo == '0); // R1
endmodule

// File: tb/burst_seq_gen_test.sv
module burst_seq_gen_test;
    localparam int CLK_PERIOD = 10;
    localparam int BB = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          adv_n = 1'b1;
    logic          order_sel = 1'b0;
    logic [BB-1:0] ext_lo = '0;
    logic [BB-1:0] burst_lo;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_seq_gen #(.BEAT_BITS(BB)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .adv_n    (adv_n),
        .order_sel(order_sel),
        .ext_lo   (ext_lo),
        .burst_lo (burst_lo)
    );

    task automatic check(input string req, input int exp);
        n_tests++;
        if (int'(burst_lo) != exp) begin
            n_fail++;
            $display("FAIL %s: burst_lo=%0d expected=%0d", req, burst_lo, exp);
        end
    endtask

    task automatic cycle(input logic s, input logic a_n, input logic [BB-1:0] v);
        start  = s;
        adv_n  = a_n;
        ext_lo = v;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        adv_n = 1'b1;
    endtask

    function automatic int expect_beat(input int mode, input int s, input int k);
        if (mode == 0) return (s + k) % 4;
        return s ^ (k % 4);
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        check("R1 in reset", 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 0);

        // R8: advances before any load
        for (int i = 0; i < 3; i++) begin
            cycle(1'b0, 1'b0, 2'd3);
            check("R8 advance ignored before load", 0);
        end

        // R2, R3, R4, R7: full sweep of orders and start values
        for (int mode = 0; mode < 2; mode++) begin
            order_sel = logic'(mode);
            for (int s = 0; s < 4; s++) begin
                cycle(1'b1, 1'b1, BB'(s));
                check("R2 first beat", s);
                for (int k = 1; k < 9; k++) begin
                    cycle(1'b0, 1'b0, 2'd0);
                    check(k > 3 ? "R7 wrap" : (mode == 0 ? "R3 linear" : "R4 interleaved"),
                          expect_beat(mode, s, k));
                end
            end
        end

        // R5: waits mid-burst in both orders
        for (int mode = 0; mode < 2; mode++) begin
            order_sel = logic'(mode);
            cycle(1'b1, 1'b1, 2'd1);
            cycle(1'b0, 1'b0, 2'd0);
            for (int w = 0; w < 3; w++) begin
                cycle(1'b0, 1'b1, 2'd2);
                check("R5 wait holds", expect_beat(mode, 1, 1));
            end
            cycle(1'b0, 1'b0, 2'd0);
            check(mode == 0 ? "R3 after wait" : "R4 after wait", expect_beat(mode, 1, 2));
        end

        // R6: load and advance on the same edge
        for (int mode = 0; mode < 2; mode++) begin
            order_sel = logic'(mode);
            cycle(1'b1, 1'b1, 2'd2);
            cycle(1'b0, 1'b0, 2'd0);
            cycle(1'b1, 1'b0, 2'd3);
            check("R6 load wins", 3);
            cycle(1'b0, 1'b0, 2'd0);
            check("R6 count restarted", expect_beat(mode, 3, 1));
        end

        // R1: reset mid-burst, then R8 again
        cycle(1'b0, 1'b0, 2'd0);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 reset mid-burst", 0);
        rst_n = 1'b1;
        @(negedge clk);
        cycle(1'b0, 1'b0, 2'd2);
        check("R8 advance ignored after reset", 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule